// File: doc/BRIEF.md
# Virtual Carrier Sense and Airtime Counter Unit

This unit keeps the MAC's time-based medium bookkeeping, all paced by one microsecond tick. The tick comes from a small prescaler running off the fast core clock. Software loads a network allocation vector (NAV) in microseconds and enables it through a control register. While the enabled count is nonzero, the medium is reported as virtually busy, and the count falls by one on every tick.

Two airtime statistics run beside the NAV on the same tick. The busy-time counter adds one for every microsecond in which clear channel assessment reports the medium busy. The transmit-duration counter measures how long the current transmission has lasted and restarts at each transmit start. Frame parsing and the CCA threshold logic live elsewhere; this block consumes only the resulting strobes and register writes.

Top module: `airtime_nav_unit`

## Requirements
- R1: A prescaler that is cleared by synchronous reset produces one tick for every CLKS_PER_US clocks (default 8). The first tick after reset release falls on the 8th rising edge.
- R2: A write with `reg_sel`=0 loads `reg_wdata` as the NAV count in microseconds. The new value replaces any remaining count. When the write and a tick fall on the same edge, the write wins.
- R3: A write with `reg_sel`=1 sets the NAV enable from `reg_wdata` bit 0. The count falls on a tick only while enable is 1. Clearing enable pauses the count and keeps the remaining value.
- R4: `nav_busy` is high exactly when enable is 1 and the count is nonzero. It drops right after the tick that takes the count from 1 to 0.
- R5: `busy_us` rises by one on each tick edge where `cca_busy` is sampled high. A level of `cca_busy` that falls between ticks has no effect.
- R6: `busy_us` saturates at its all-ones value (0xFFFF with the default 16-bit width).
- R7: A write with `reg_sel`=2 clears `busy_us` to zero. On the same edge, the clear wins over an increment. A write with `reg_sel`=3 has no effect.
- R8: `tx_start` clears `tx_us` to zero, and this wins over a coincident tick. After that, `tx_us` rises by one per tick and saturates at all-ones. It stays at zero from reset until the first `tx_start`.
- R9: While reset is low, `nav_busy`, `busy_us` and `tx_us` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (8 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 NAV count, 1 NAV control, 2 busy clear, 3 none |
| reg_wdata | input | DATA_W | Write data |
| cca_busy | input | 1 | Physical medium busy from clear channel assessment |
| tx_start | input | 1 | One-cycle transmit start strobe |
| nav_busy | output | 1 | NAV countdown running (medium virtually busy) |
| busy_us | output | BUSY_W | Accumulated busy microseconds |
| tx_us | output | TXD_W | Microseconds since last transmit start |

## Verification
The hardest cases are the edge collisions: a NAV reload, a busy clear or a transmit start landing on the very edge where a tick fires. None of the outputs show the prescaler phase. The stimulus therefore recovers that phase by counting rising edges since reset release, and from that count it drives writes and strobes so that they land exactly on a tick edge, or exactly between two ticks. Saturation cannot be reached with 16-bit counters inside the run length, so a second instance with 4-bit counters is driven into saturation.

// File: rtl/airtime_nav_pkg.sv
// Shared definitions for the NAV / airtime unit: register select codes
// and the control-bit position of the NAV enable.
package airtime_nav_pkg;
    typedef enum logic [1:0] {
        SEL_NAV_COUNT = 2'd0,
        SEL_NAV_CTRL  = 2'd1,
        SEL_BUSY_CLR  = 2'd2,
        SEL_NONE      = 2'd3
    } reg_sel_e;

    localparam int NAV_EN_BIT = 0;
endpackage

// File: rtl/us_prescaler.sv
// Divides the core clock down to a one-cycle microsecond tick.
// Assumes CLKS_PER_US >= 2; counter width is derived from it.
module us_prescaler #(
    parameter int CLKS_PER_US = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (CLKS_PER_US > 2) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_US - 1);

    logic [PW-1:0] phase;

    // tick marks the final clock of each microsecond
    assign tick = (phase == LAST);

    // phase counter, wraps after the tick cycle
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end
endmodule

// File: rtl/nav_countdown.sv
// Software-loaded virtual carrier sense countdown. Counts down once per
// tick while enabled; a load replaces the remaining value and wins over a
// coincident decrement. Assumes load and control writes are one-cycle strobes.
module nav_countdown #(
    parameter int NAV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [NAV_W-1:0] load_val,
    input  logic             ctl_wr,
    input  logic             ctl_en,
    output logic             running
);
    logic [NAV_W-1:0] remaining;
    logic             enabled;

    // enable flag written by software
    always_ff @(posedge clk) begin
        if (!rst_n)      enabled <= 1'b0;
        else if (ctl_wr) enabled <= ctl_en;
    end

    // remaining microseconds: load has priority over tick decrement
    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining <= '0;
        else if (load)
            remaining <= load_val;
        else if (tick && enabled && (remaining != '0))
            remaining <= remaining - 1'b1;
    end

    // virtual busy while an enabled count is outstanding
    assign running = enabled && (remaining != '0);
endmodule

// File: rtl/sat_us_counter.sv
// Saturating microsecond accumulator: adds one on a tick when the qualify
// input is high, clears on request (clear wins), holds at all-ones.
module sat_us_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         qualify,
    input  logic         clear,
    output logic [W-1:0] value
);
    // accumulate with saturation, clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (clear)
            value <= '0;
        else if (tick && qualify && (value != '1))
            value <= value + 1'b1;
    end
endmodule

// File: rtl/airtime_nav_unit.sv
// Top of the NAV and airtime unit. One prescaler tick paces the NAV
// countdown, the medium-busy accumulator and the transmit-duration counter.
// Assumes cca_busy and tx_start are synchronous to clk.
module airtime_nav_unit
    import airtime_nav_pkg::*;
#(
    parameter int CLKS_PER_US = 8,
    parameter int DATA_W      = 16,
    parameter int BUSY_W      = 16,
    parameter int TXD_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              cca_busy,
    input  logic              tx_start,
    output logic              nav_busy,
    output logic [BUSY_W-1:0] busy_us,
    output logic [TXD_W-1:0]  tx_us
);
    logic us_tick;
    logic wr_count, wr_ctrl, wr_clr;
    logic tx_armed;

    // register write decode
    assign wr_count = reg_we && (reg_sel == SEL_NAV_COUNT);
    assign wr_ctrl  = reg_we && (reg_sel == SEL_NAV_CTRL);
    assign wr_clr   = reg_we && (reg_sel == SEL_BUSY_CLR);

    us_prescaler #(.CLKS_PER_US(CLKS_PER_US)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (us_tick)
    );

    nav_countdown #(.NAV_W(DATA_W)) u_nav (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (us_tick),
        .load    (wr_count),
        .load_val(reg_wdata),
        .ctl_wr  (wr_ctrl),
        .ctl_en  (reg_wdata[NAV_EN_BIT]),
        .running (nav_busy)
    );

    sat_us_counter #(.W(BUSY_W)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (us_tick),
        .qualify(cca_busy),
        .clear  (wr_clr),
        .value  (busy_us)
    );

    // transmit timing starts only after the first transmit start
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_armed <= 1'b0;
        else if (tx_start) tx_armed <= 1'b1;
    end

    sat_us_counter #(.W(TXD_W)) u_txdur (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (us_tick),
        .qualify(tx_armed),
        .clear  (tx_start),
        .value  (tx_us)
    );
endmodule

// File: rtl/airtime_nav_unit_chk.sv
// Property checker for airtime_nav_unit, attached by bind below.
module airtime_nav_unit_chk #(
    parameter int CLKS_PER_US = 8,
    parameter int BUSY_W      = 16,
    parameter int TXD_W       = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic              tx_start,
    input logic              us_tick,
    input logic              nav_busy,
    input logic [BUSY_W-1:0] busy_us,
    input logic [TXD_W-1:0]  tx_us
);
    logic clr_wr;
    logic nav_wr;
    int   gap;

    assign clr_wr = reg_we && (reg_sel == 2'd2);
    assign nav_wr = reg_we && ((reg_sel == 2'd0) || (reg_sel == 2'd1));

    // cycles since the last tick, for the tick period check
    always_ff @(posedge clk) begin
        if (!rst_n)       gap <= 0;
        else if (us_tick) gap <= 0;
        else              gap <= gap + 1;
    end

    a_r1_tick_period: assert property (@(posedge clk) disable iff (!rst_n)
        us_tick |-> (gap == CLKS_PER_US - 1));

    a_r4_nav_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nav_busy) |-> ($past(us_tick) || $past(nav_wr)));

    a_r5_busy_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!us_tick && !clr_wr) |=> $stable(busy_us));

    a_r6_busy_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy_us == '1) && !clr_wr) |=> (busy_us == '1));

    a_r7_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (busy_us == '0));

    a_r8_tx_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> (tx_us == '0));

    a_r8_tx_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!us_tick && !tx_start) |=> $stable(tx_us));
endmodule

bind airtime_nav_unit airtime_nav_unit_chk #(
    .CLKS_PER_US(CLKS_PER_US),
    .BUSY_W     (BUSY_W),
    .TXD_W      (TXD_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_we  (reg_we),
    .reg_sel (reg_sel),
    .tx_start(tx_start),
    .us_tick (us_tick),
    .nav_busy(nav_busy),
    .busy_us (busy_us),
    .tx_us   (tx_us)
);

// File: tb/airtime_nav_unit_bench.sv
// Scoreboard bench: stimulus tasks queue expected values tagged with the
// rising-edge number they must appear after; a negedge monitor compares.
module airtime_nav_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int US = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [15:0] reg_wdata = '0;
    logic        cca_busy = 1'b0;
    logic        tx_start = 1'b0;
    logic        nav_busy;
    logic [15:0] busy_us;
    logic [15:0] tx_us;

    logic        cca_n = 1'b0;
    logic        txs_n = 1'b0;
    logic        nav_n;
    logic [3:0]  busy_n;
    logic [3:0]  tx_n;

    int edge_n = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    sig;
        int    val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    airtime_nav_unit u_airtime_nav_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cca_busy(cca_busy), .tx_start(tx_start),
        .nav_busy(nav_busy), .busy_us(busy_us), .tx_us(tx_us)
    );

    airtime_nav_unit #(.BUSY_W(4), .TXD_W(4)) u_airtime_nav_unit_narrow (
        .clk(clk), .rst_n(rst_n), .reg_we(1'b0), .reg_sel(2'd3),
        .reg_wdata(16'h0000), .cca_busy(cca_n), .tx_start(txs_n),
        .nav_busy(nav_n), .busy_us(busy_n), .tx_us(tx_n)
    );

    always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

    function automatic int sig_val(input int s);
        case (s)
            0:       return int'(nav_busy);
            1:       return int'(busy_us);
            2:       return int'(tx_us);
            3:       return int'(busy_n);
            default: return int'(tx_n);
        endcase
    endfunction

    task automatic expect_at(input int at, input int sig, input int val, input string tag);
        exp_t it;
        int i = 0;
        it.at = at; it.sig = sig; it.val = val; it.tag = tag;
        while (i < sb.size() && sb[i].at <= at) i++;
        sb.insert(i, it);
    endtask

    task automatic check_now(input int sig, input int val, input string tag);
        checks++;
        if (sig_val(sig) != val) begin
            errors++;
            $display("FAIL %s sig%0d: actual=%0d expected=%0d", tag, sig, sig_val(sig), val);
        end
    endtask

    // monitor: pop and compare expectations due at this edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= edge_n) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if (it.at != edge_n || sig_val(it.sig) != it.val) begin
                errors++;
                $display("FAIL %s sig%0d edge %0d: actual=%0d expected=%0d",
                         it.tag, it.sig, it.at, sig_val(it.sig), it.val);
            end
        end
    end

    task automatic sync_tick(output int e);
        @(negedge clk);
        while (edge_n % US != 0) @(negedge clk);
        e = edge_n;
    endtask

    task automatic wait_edge(input int n);
        while (edge_n < n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [15:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
    endtask

    task automatic pulse_tx();
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    initial begin
        int e;
        repeat (3) @(negedge clk);
        check_now(0, 0, "R9 nav_busy in reset");
        check_now(1, 0, "R9 busy_us in reset");
        check_now(2, 0, "R9 tx_us in reset");
        rst_n = 1'b1;

        // R3/R4: enable gating and exact drop tick
        sync_tick(e);
        expect_at(e + 1, 0, 0, "R3 loaded but disabled");
        expect_at(e + 2, 0, 1, "R4 running after enable");
        expect_at(e + 23, 0, 1, "R4 still running before last tick");
        expect_at(e + 24, 0, 0, "R4 drop on tick reaching zero");
        expect_at(e + 24, 2, 0, "R8 tx_us idle before first start");
        reg_wr(2'd0, 16'd3);
        reg_wr(2'd1, 16'd1);
        wait_edge(e + 25);

        // R3: disable pauses, re-enable resumes with kept count
        sync_tick(e);
        expect_at(e + 1, 0, 1, "R2 load while enabled");
        expect_at(e + 17, 0, 0, "R3 disabled");
        expect_at(e + 40, 0, 0, "R3 paused");
        expect_at(e + 41, 0, 1, "R3 resumed");
        expect_at(e + 63, 0, 1, "R3 kept remaining count");
        expect_at(e + 64, 0, 0, "R3 ran out after kept count");
        reg_wr(2'd0, 16'd5);
        wait_edge(e + 16);
        reg_wr(2'd1, 16'd0);
        wait_edge(e + 40);
        reg_wr(2'd1, 16'd1);
        wait_edge(e + 65);

        // R2: reload while counting replaces remainder
        sync_tick(e);
        expect_at(e + 23, 0, 1, "R2 reload running");
        expect_at(e + 24, 0, 0, "R2 reload replaced remainder");
        reg_wr(2'd0, 16'd10);
        wait_edge(e + 12);
        reg_wr(2'd0, 16'd2);
        wait_edge(e + 25);

        // R2: load on tick edge wins over decrement
        sync_tick(e);
        expect_at(e + 23, 0, 1, "R2 load on tick kept full value");
        expect_at(e + 24, 0, 0, "R2 load on tick drop");
        wait_edge(e + 7);
        reg_wr(2'd0, 16'd2);
        wait_edge(e + 25);

        // R4: zero load gives no busy; R7: select 3 ignored
        sync_tick(e);
        expect_at(e + 1, 0, 0, "R4 zero count not busy");
        expect_at(e + 2, 1, 0, "R7 select 3 no effect");
        reg_wr(2'd0, 16'd0);
        reg_wr(2'd3, 16'hFFFF);

        // R1/R5: busy counted only on tick edges
        sync_tick(e);
        expect_at(e + 7, 1, 0, "R1 no tick before 8 clocks");
        expect_at(e + 8, 1, 1, "R5 first busy microsecond");
        expect_at(e + 24, 1, 3, "R5 three busy microseconds");
        expect_at(e + 40, 1, 3, "R5 idle medium holds");
        cca_busy = 1'b1;
        wait_edge(e + 24);
        cca_busy = 1'b0;
        wait_edge(e + 41);

        // R5: busy level between ticks ignored
        sync_tick(e);
        expect_at(e + 8, 1, 3, "R5 between-tick busy ignored");
        @(negedge clk);
        cca_busy = 1'b1;
        wait_edge(e + 5);
        cca_busy = 1'b0;
        wait_edge(e + 9);

        // R7: clear on tick edge wins over increment
        sync_tick(e);
        expect_at(e + 8, 1, 0, "R7 clear wins on tick");
        expect_at(e + 16, 1, 1, "R7 counts after clear");
        cca_busy = 1'b1;
        wait_edge(e + 7);
        reg_wr(2'd2, 16'd0);
        wait_edge(e + 16);
        cca_busy = 1'b0;

        // R8: transmit duration and restart on tick edge
        sync_tick(e);
        expect_at(e + 7, 2, 0, "R8 cleared at start");
        expect_at(e + 8, 2, 1, "R8 first microsecond");
        expect_at(e + 40, 2, 5, "R8 five microseconds");
        expect_at(e + 48, 2, 0, "R8 restart wins on tick");
        expect_at(e + 56, 2, 1, "R8 counts after restart");
        pulse_tx();
        wait_edge(e + 47);
        pulse_tx();
        wait_edge(e + 57);

        // R6/R8: saturation on the narrow instance
        sync_tick(e);
        expect_at(e + 112, 3, 14, "R6 below saturation");
        expect_at(e + 120, 3, 15, "R6 reaches all-ones");
        expect_at(e + 160, 3, 15, "R6 holds all-ones");
        expect_at(e + 160, 4, 15, "R8 tx saturates");
        cca_n = 1'b1;
        txs_n = 1'b1;
        @(negedge clk);
        txs_n = 1'b0;
        wait_edge(e + 161);
        cca_n = 1'b0;

        repeat (2) @(negedge clk);
        if (sb.size() > 0) begin
            errors += sb.size();
            checks += sb.size();
            $display("FAIL unchecked expectations: actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule